// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block drives the command pins of a DDR SDRAM from reset until the memory can accept normal traffic. After reset it holds the clock enable low and drives NOP for the power-up wait, then raises clock enable and issues the fixed start-up command series. That series is: precharge-all, extended mode load (DLL on), mode load with DLL reset, precharge-all, two auto refreshes, and a mode load with DLL reset cleared. At the end it raises a done flag.

All waits are derived from a clock-frequency parameter and nanosecond or microsecond parameters. One down-counter, reloaded whenever the sequencer moves to a new step, times every wait. The done flag is held back until at least the DLL lock count has elapsed since the DLL-reset mode load. The mode register values are parameters. The controller that sits behind this block starts issuing commands once it sees the done flag.

Top module: `ddr_init_seq`

## Requirements
- R1: While `rst_n` is sampled low at a rising clock edge, the block returns to its start state. From the following cycle `ddr_cke` is 0, the command is NOP and `init_done` is 0.
- R2: For the first PWRUP_CYC = PWRUP_US*CLK_MHZ cycles after reset release (cycles 0 to PWRUP_CYC-1), `ddr_cke` is 0 and the command is NOP. `ddr_cke` is 1 from cycle PWRUP_CYC on. No command other than NOP appears while `ddr_cke` is 0.
- R3: Once `ddr_cke` has risen, it stays 1 until the next reset.
- R4: Commands are encoded on {cs_n, ras_n, cas_n, we_n} as NOP=0111, PRECHARGE=0010, AUTO REFRESH=0001 and MODE LOAD=0000. Each non-NOP command lasts exactly one cycle and is followed by NOP.
- R5: Exactly seven commands are issued, in this order:
  1. PRECHARGE with address 0x0400 (only A10 set, meaning all banks).
  2. MODE LOAD with bank 01 and address EMR_VAL.
  3. MODE LOAD with bank 00 and address MR_VAL with bit DLL_RST_BIT set.
  4. PRECHARGE with address 0x0400.
  5. AUTO REFRESH.
  6. AUTO REFRESH.
  7. MODE LOAD with bank 00 and address MR_VAL with bit DLL_RST_BIT cleared.
- R6: A wait in cycles is max(2, ceil(ns*CLK_MHZ/1000)). The first PRECHARGE is issued tRP cycles after `ddr_cke` rises. The gap to the next command is tRP after a PRECHARGE, tMRD after a MODE LOAD and tRFC after an AUTO REFRESH.
- R7: `init_done` rises exactly max(DLL_LOCK_CYC, 2*tMRD + tRP + 2*tRFC + 1) cycles after the DLL-reset mode load. It is never earlier than DLL_LOCK_CYC cycles after that load.
- R8: Once `init_done` is 1, it stays 1 and the command stays NOP until the next reset.
- R9: A reset applied at any point in the sequence aborts it. The next release restarts the full sequence with the R2 timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the sequencer and the memory |
| rst_n | input | 1 | Synchronous active-low reset |
| ddr_cke | output | 1 | Memory clock enable |
| ddr_cs_n | output | 1 | Chip select, active low |
| ddr_ras_n | output | 1 | Row strobe, active low |
| ddr_cas_n | output | 1 | Column strobe, active low |
| ddr_we_n | output | 1 | Write enable, active low |
| ddr_ba | output | 2 | Bank address |
| ddr_addr | output | 13 | Address bus / mode value |
| init_done | output | 1 | Initialization complete, held until reset |

## Verification
Every result of this block is a fixed cycle offset from reset release. The bench counts cycles from the release edge and samples on the falling edge. It records the cycle at which `ddr_cke` rises, the cycle of each non-NOP command and the cycle at which `init_done` rises. These recorded cycles are compared with offsets computed from the R2, R6 and R7 formulas. Aborting resets are placed at a directed point just after the DLL-reset load and at a seeded random cycle. In each case the bench checks the reset outputs on the falling edge after the reset edge and then repeats the full timing check.

// File: rtl/ddr_init_pkg.sv
// Shared types for the DDR power-up sequencer.
// Assumes: command code values match the memory's {cs_n,ras_n,cas_n,we_n} truth table.
package ddr_init_pkg;

    typedef enum logic [3:0] {
        ST_PWRUP,
        ST_CKE,
        ST_PRE1,
        ST_EMR,
        ST_MR_DLLRST,
        ST_PRE2,
        ST_REF1,
        ST_REF2,
        ST_MR_RUN,
        ST_LOCK,
        ST_READY
    } init_step_t;

    typedef enum logic [3:0] {
        CMD_LMR = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_NOP = 4'b0111
    } ddr_cmd_t;

    // Nanoseconds to clock cycles, rounded up, never below two cycles.
    function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned mhz);
        int unsigned c;
        c = (ns * mhz + 999) / 1000;
        return (c < 2) ? 2 : c;
    endfunction

endpackage

// File: rtl/init_wait_timer.sv
// Down-counter that times the wait of each sequencer step.
// Loads on request, counts to zero and holds there; expired flags zero.
// Assumes: the owner loads (length-1) on every step entry.
module init_wait_timer #(
    parameter int          CNT_W   = 16,
    parameter int unsigned RST_VAL = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt;

    // Reload on step entry, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= CNT_W'(RST_VAL);
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

    // Without a load, a running count moves down by exactly one (wait spacing).
    assert_count_down_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

    // Zero is a resting value until the next load.
    assert_hold_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt == '0) |=> (cnt == '0));

endmodule

// File: rtl/init_cmd_encoder.sv
// Maps the current sequencer step to the memory command pins.
// A real command is driven only in the first cycle of its step; NOP otherwise.
// Assumes: the caller raises 'fresh' for exactly one cycle on step entry.
module init_cmd_encoder
    import ddr_init_pkg::*;
#(
    parameter int          ADDR_W      = 13,
    parameter int          BA_W        = 2,
    parameter logic [12:0] EMR_VAL     = 13'h0000,
    parameter logic [12:0] MR_VAL      = 13'h0062,
    parameter int          DLL_RST_BIT = 8
) (
    input  init_step_t        step,
    input  logic              fresh,
    output logic              cke,
    output ddr_cmd_t          cmd,
    output logic [BA_W-1:0]   ba,
    output logic [ADDR_W-1:0] addr
);

    localparam logic [ADDR_W-1:0] DLL_MASK = ADDR_W'(1) << DLL_RST_BIT;
    localparam logic [ADDR_W-1:0] PRE_ALL  = ADDR_W'(1) << 10;

    // Clock enable is low only while the power-up wait runs.
    assign cke = (step != ST_PWRUP);

    // Command, bank and address for the step's first cycle.
    always_comb begin
        cmd  = CMD_NOP;
        ba   = '0;
        addr = '0;
        if (fresh) begin
            case (step)
                ST_PRE1, ST_PRE2: begin
                    cmd  = CMD_PRE;
                    addr = PRE_ALL;
                end
                ST_EMR: begin
                    cmd  = CMD_LMR;
                    ba   = BA_W'(1);
                    addr = ADDR_W'(EMR_VAL);
                end
                ST_MR_DLLRST: begin
                    cmd  = CMD_LMR;
                    addr = ADDR_W'(MR_VAL) | DLL_MASK;
                end
                ST_REF1, ST_REF2: cmd = CMD_REF;
                ST_MR_RUN: begin
                    cmd  = CMD_LMR;
                    addr = ADDR_W'(MR_VAL) & ~DLL_MASK;
                end
                default: cmd = CMD_NOP;
            endcase
        end
    end

endmodule

// File: rtl/ddr_init_seq.sv
// DDR SDRAM power-up initialization sequencer (top).
// Steps through the fixed start-up command series, timing every wait with one
// reloaded down-counter, and raises init_done when the memory may be used.
// Assumes: clk runs at CLK_MHZ and supplies are stable when rst_n is released.
module ddr_init_seq
    import ddr_init_pkg::*;
#(
    parameter int unsigned CLK_MHZ      = 100,
    parameter int unsigned PWRUP_US     = 200,
    parameter int unsigned TRP_NS       = 20,
    parameter int unsigned TMRD_NS      = 15,
    parameter int unsigned TRFC_NS      = 80,
    parameter int unsigned DLL_LOCK_CYC = 200,
    parameter logic [12:0] EMR_VAL      = 13'h0000,
    parameter logic [12:0] MR_VAL       = 13'h0062,
    parameter int          DLL_RST_BIT  = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    output logic        ddr_cke,
    output logic        ddr_cs_n,
    output logic        ddr_ras_n,
    output logic        ddr_cas_n,
    output logic        ddr_we_n,
    output logic [1:0]  ddr_ba,
    output logic [12:0] ddr_addr,
    output logic        init_done
);

    localparam int unsigned PWRUP_C = (PWRUP_US * CLK_MHZ < 1) ? 1 : PWRUP_US * CLK_MHZ;
    localparam int unsigned TRP_C   = ns_to_cyc(TRP_NS, CLK_MHZ);
    localparam int unsigned TMRD_C  = ns_to_cyc(TMRD_NS, CLK_MHZ);
    localparam int unsigned TRFC_C  = ns_to_cyc(TRFC_NS, CLK_MHZ);
    localparam int unsigned POST_C  = 2 * TMRD_C + TRP_C + 2 * TRFC_C;
    localparam int unsigned LOCK_C  = (DLL_LOCK_CYC > POST_C) ? DLL_LOCK_CYC - POST_C : 1;
    localparam int unsigned BOUND_C = PWRUP_C + LOCK_C + TRP_C + TMRD_C + TRFC_C;
    localparam int          CNT_W   = $clog2(BOUND_C + 1);
    localparam int          SINCE_W = $clog2(DLL_LOCK_CYC + 2) + 1;

    init_step_t       step;
    init_step_t       nxt;
    logic             fresh;
    logic             expired;
    logic             advance;
    logic [CNT_W-1:0] load_val;
    ddr_cmd_t         cmd;

    // Length in cycles of each step.
    function automatic int unsigned step_len(input init_step_t s);
        case (s)
            ST_PWRUP:               return PWRUP_C;
            ST_CKE, ST_PRE1,
            ST_PRE2:                return TRP_C;
            ST_EMR, ST_MR_DLLRST,
            ST_MR_RUN:              return TMRD_C;
            ST_REF1, ST_REF2:       return TRFC_C;
            ST_LOCK:                return LOCK_C;
            default:                return 1;
        endcase
    endfunction

    assign advance  = expired && (step != ST_READY);
    assign nxt      = (step == ST_READY) ? ST_READY : init_step_t'(step + 4'd1);
    assign load_val = CNT_W'(step_len(nxt) - 1);

    // Step register plus the first-cycle marker that gates the command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step  <= ST_PWRUP;
            fresh <= 1'b1;
        end else if (advance) begin
            step  <= nxt;
            fresh <= 1'b1;
        end else begin
            fresh <= 1'b0;
        end
    end

    init_wait_timer #(
        .CNT_W   (CNT_W),
        .RST_VAL (PWRUP_C - 1)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (advance),
        .load_val (load_val),
        .expired  (expired)
    );

    init_cmd_encoder #(
        .ADDR_W      (13),
        .BA_W        (2),
        .EMR_VAL     (EMR_VAL),
        .MR_VAL      (MR_VAL),
        .DLL_RST_BIT (DLL_RST_BIT)
    ) u_enc (
        .step  (step),
        .fresh (fresh),
        .cke   (ddr_cke),
        .cmd   (cmd),
        .ba    (ddr_ba),
        .addr  (ddr_addr)
    );

    assign {ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n} = cmd;
    assign init_done = (step == ST_READY);

    // ---------------- assertions ----------------
    logic [SINCE_W-1:0] since_dllrst;

    // Cycles elapsed since the DLL-reset mode load, saturating (checker only).
    always_ff @(posedge clk) begin
        if (!rst_n)
            since_dllrst <= '0;
        else if (cmd == CMD_LMR && ddr_addr[DLL_RST_BIT] && ddr_ba == 2'b00)
            since_dllrst <= SINCE_W'(1);
        else if (since_dllrst != '0 && since_dllrst != '1)
            since_dllrst <= since_dllrst + 1'b1;
    end

    assert_nop_cke_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !ddr_cke |-> (cmd == CMD_NOP));

    assert_cke_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ddr_cke |=> ddr_cke);

    assert_one_cycle_cmd_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd != CMD_NOP) |=> (cmd == CMD_NOP));

    assert_precharge_all_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_PRE) |-> ddr_addr[10]);

    assert_dll_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_done) |-> (since_dllrst >= SINCE_W'(DLL_LOCK_CYC)));

    assert_done_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    assert_quiet_after_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> (cmd == CMD_NOP));

endmodule

// File: tb/ddr_init_seq_bench.sv
module ddr_init_seq_bench;

    localparam int          CLK_PERIOD  = 10;
    localparam int          CLK_MHZ     = 100;
    localparam int          PWRUP_US    = 200;
    localparam int          TRP_NS      = 20;
    localparam int          TMRD_NS     = 15;
    localparam int          TRFC_NS     = 80;
    localparam int          DLL_LOCK    = 200;
    localparam logic [12:0] EMR_VAL     = 13'h0000;
    localparam logic [12:0] MR_VAL      = 13'h0062;
    localparam int          DLL_BIT     = 8;
    localparam int          WATCHDOG    = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ddr_cke, ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n, init_done;
    logic [1:0]  ddr_ba;
    logic [12:0] ddr_addr;

    int n_chk = 0;
    int n_fail = 0;
    int cyc_total = 0;

    int exp_cyc [7];
    logic [3:0]  exp_code [7];
    logic [1:0]  exp_ba [7];
    logic [12:0] exp_addr [7];
    int exp_cke;
    int exp_done;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ddr_init_seq #(
        .CLK_MHZ (CLK_MHZ), .PWRUP_US (PWRUP_US), .TRP_NS (TRP_NS),
        .TMRD_NS (TMRD_NS), .TRFC_NS (TRFC_NS), .DLL_LOCK_CYC (DLL_LOCK),
        .EMR_VAL (EMR_VAL), .MR_VAL (MR_VAL), .DLL_RST_BIT (DLL_BIT)
    ) u_ddr_init_seq (
        .clk (clk), .rst_n (rst_n), .ddr_cke (ddr_cke), .ddr_cs_n (ddr_cs_n),
        .ddr_ras_n (ddr_ras_n), .ddr_cas_n (ddr_cas_n), .ddr_we_n (ddr_we_n),
        .ddr_ba (ddr_ba), .ddr_addr (ddr_addr), .init_done (init_done)
    );

    function automatic int wait_cyc(input int ns);
        int c;
        c = (ns * CLK_MHZ + 999) / 1000;
        return (c < 2) ? 2 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Expected schedule from R2, R5, R6, R7.
    function automatic void build_expect();
        int trp, tmrd, trfc;
        trp  = wait_cyc(TRP_NS);
        tmrd = wait_cyc(TMRD_NS);
        trfc = wait_cyc(TRFC_NS);
        exp_cke    = PWRUP_US * CLK_MHZ;
        exp_cyc[0] = exp_cke + trp;
        exp_cyc[1] = exp_cyc[0] + trp;
        exp_cyc[2] = exp_cyc[1] + tmrd;
        exp_cyc[3] = exp_cyc[2] + tmrd;
        exp_cyc[4] = exp_cyc[3] + trp;
        exp_cyc[5] = exp_cyc[4] + trfc;
        exp_cyc[6] = exp_cyc[5] + trfc;
        exp_done   = exp_cyc[2] + imax(DLL_LOCK, 2 * tmrd + trp + 2 * trfc + 1);
        exp_code = '{4'b0010, 4'b0000, 4'b0000, 4'b0010, 4'b0001, 4'b0001, 4'b0000};
        exp_ba   = '{2'b00, 2'b01, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00};
        exp_addr[0] = 13'h0400;
        exp_addr[1] = EMR_VAL;
        exp_addr[2] = MR_VAL | (13'd1 << DLL_BIT);
        exp_addr[3] = 13'h0400;
        exp_addr[4] = 13'h0000;
        exp_addr[5] = 13'h0000;
        exp_addr[6] = MR_VAL & ~(13'd1 << DLL_BIT);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Reset outputs (R1): CKE low, NOP, not done.
    task automatic chk_reset_outputs(input string req);
        chk({req, " cke low"}, int'(ddr_cke), 0);
        chk({req, " cmd NOP"}, int'({ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n}), 4'b0111);
        chk({req, " done low"}, int'(init_done), 0);
    endtask

    // One sequence from reset release; abort_at >= 0 resets at that cycle.
    task automatic run_seq(input int hold, input int abort_at);
        int cke_rise = -1, done_at = -1, ncmd = 0;
        int low_cmd = 0, cke_drop = 0, after_done = 0, done_drop = 0;
        int got_cyc [7];
        logic [3:0]  got_code [7];
        logic [1:0]  got_ba [7];
        logic [12:0] got_addr [7];
        logic [3:0]  cmd;
        @(negedge clk);
        rst_n = 1'b0;
        repeat (hold) @(negedge clk);
        chk_reset_outputs("R1");
        rst_n = 1'b1;
        for (int c = 0; c < exp_done + 60; c++) begin
            if (c == abort_at) begin
                rst_n = 1'b0;
                @(negedge clk);
                chk_reset_outputs("R9 abort");
                return;
            end
            cmd = {ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n};
            if (!ddr_cke && cmd != 4'b0111) low_cmd++;
            if (cke_rise < 0 && ddr_cke) cke_rise = c;
            if (cke_rise >= 0 && !ddr_cke) cke_drop++;
            if (cmd != 4'b0111) begin
                if (done_at >= 0) after_done++;
                else if (ncmd < 7) begin
                    got_cyc[ncmd] = c; got_code[ncmd] = cmd;
                    got_ba[ncmd] = ddr_ba; got_addr[ncmd] = ddr_addr;
                end
                if (done_at < 0) ncmd++;
            end
            if (init_done && done_at < 0) done_at = c;
            if (done_at >= 0 && !init_done) done_drop++;
            if (done_at >= 0 && c >= done_at + 40) break;
            @(negedge clk);
        end
        chk("R2 cke rise cycle", cke_rise, exp_cke);
        chk("R2 command while cke low", low_cmd, 0);
        chk("R3 cke drops", cke_drop, 0);
        chk("R4 command count", ncmd, 7);
        for (int k = 0; k < 7 && k < ncmd; k++) begin
            chk($sformatf("R4 code of command %0d", k), int'(got_code[k]), int'(exp_code[k]));
            chk($sformatf("R5 bank of command %0d", k), int'(got_ba[k]), int'(exp_ba[k]));
            chk($sformatf("R5 address of command %0d", k), int'(got_addr[k]), int'(exp_addr[k]));
            chk($sformatf("R6 cycle of command %0d", k), got_cyc[k], exp_cyc[k]);
        end
        chk("R7 done cycle", done_at, exp_done);
        chk("R8 commands after done", after_done, 0);
        chk("R8 done drops", done_drop, 0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        build_expect();
        run_seq(3, -1);
        run_seq(1, exp_cyc[2] + 5);                                  // directed: mid DLL lock
        run_seq(int'($urandom_range(1, 5)), -1);                     // R9 restart
        run_seq(2, int'($urandom_range(0, exp_done - 1)));           // random abort
        run_seq(int'($urandom_range(1, 5)), -1);
        summary();
    end

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        cyc_total++;
        if (cyc_total > WATCHDOG) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc_total, WATCHDOG);
            summary();
        end
    end

endmodule